// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces a system reset for a processor subsystem. It merges three reasons for reset into one output: a supply-low flag from an external voltage comparator, a push-button manual reset, and the expiry of a watchdog timer. The reset is presented twice, once active-high and once active-low. Each raw input crosses into the clock domain through a synchronizer. A saturating counter then filters it, so a pulse shorter than the filter length never reaches the output.

Whenever any reason is present, a hold counter is reloaded. Reset is released only after that counter has run down a full hold period with no reason present. A reason that arrives during the countdown therefore restarts the whole period.

The watchdog counts clock cycles while reset is released. It is reloaded by every rising or falling edge on its monitor input. A build-time parameter selects that input: either a dedicated kick pin or the data line of a two-wire serial bus, so ordinary bus traffic can keep the watchdog alive. Every duration is a parameter expressed in clock cycles.

Top module: `sup_reset_ctrl`

## Requirements
- R1: `rst_out_n` is always the logical inverse of `rst_out`.
- R2: While `rst` is high, `rst_out` is 1. After `rst` falls, `rst_out` stays 1 for exactly HOLD_CYC clock cycles and then drops.
- R3: A high level on `supply_low` held for at least LOWV_FILT_CYC cycles drives `rst_out` to 1 on the (LOWV_FILT_CYC+3)-th rising edge after the level is applied, assuming two synchronizer stages. A shorter high pulse leaves `rst_out` at 0.
- R4: A low level on `man_rst_n` (active-low: 0 means pressed) held for at least MAN_FILT_CYC cycles drives `rst_out` to 1 on the (MAN_FILT_CYC+3)-th rising edge. A shorter low pulse leaves `rst_out` at 0.
- R5: Consider an accepted pulse of P cycles whose filter length is F. `rst_out` returns to 0 on the (P+F+HOLD_CYC+2)-th edge counted from the start of the pulse, and stays 1 continuously until then.
- R6: A cause that becomes valid while the hold countdown is running reloads the hold. Release then comes HOLD_CYC cycles after that new cause clears, as given by R5 measured from the new cause's pulse.
- R7: If reset is released and no edge occurs on the selected monitor input, `rst_out` goes to 1 exactly WDOG_CYC cycles after release. It then stays 1 for HOLD_CYC cycles.
- R8: Both rising and falling edges on the selected monitor input reload the watchdog. Toggling at any interval shorter than WDOG_CYC keeps `rst_out` at 0.
- R9: KICK_SEL=0 selects `wd_kick` as the monitor input and KICK_SEL=1 selects `bus_sda`. Activity on the unselected pin does not reload the watchdog.
- R10: The watchdog is held cleared while reset is asserted, so every release starts a full WDOG_CYC period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the block; also forces the reset output |
| supply_low | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| man_rst_n | input | 1 | Asynchronous push-button input, 0 = reset requested |
| wd_kick | input | 1 | Asynchronous dedicated watchdog kick pin |
| bus_sda | input | 1 | Asynchronous two-wire bus data line, usable as watchdog kick |
| rst_out | output | 1 | System reset, active-high |
| rst_out_n | output | 1 | System reset, active-low |

## Verification
A filter counter that counts wrongly or saturates at the wrong value moves the reset edge. The rise then lands one or more cycles away from LEN+3, or a short pulse that should be rejected produces a reset within a few cycles. A hold counter that is not reloaded shows up as an early release during the restart test, up to HOLD_CYC cycles before the expected edge. A watchdog counter that is not cleared during reset, or that ignores one edge polarity, causes an early bite or a bite while kicks are still arriving. Either fault is visible at `rst_out` within one WDOG_CYC period after release.

// File: rtl/sup_pkg.sv
package sup_pkg;

    // Causes that can hold the system in reset.
    typedef struct packed {
        logic lowv;
        logic man;
        logic wdog;
    } cause_t;

    // Monitor input selection.
    localparam int KICK_PIN = 0;
    localparam int KICK_BUS = 1;

    // Width of a counter that must hold values 0..n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic cause_any(input cause_t c);
        return c.lowv | c.man | c.wdog;
    endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sup_filter.sv
module sup_filter #(
    parameter int   LEN  = 4,
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic state
);
    localparam int CW = sup_pkg::cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;
    logic          state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= INIT;
            cnt_q   <= '0;
        end else if (din == state_q) begin
            cnt_q   <= '0;
        end else if (cnt_q == LAST) begin
            state_q <= din;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign state = state_q;

    // R3 / R4: the filtered level only moves toward the level seen at its input
    a_r3_filter_follows_input: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q)) |-> ($past(din) == state_q));

    // R3 / R4: the run counter never passes the rejection length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
    parameter int CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic mon,
    output logic bite
);
    localparam int CW = sup_pkg::cnt_width(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt_q;
    logic          mon_prev_q;
    logic          kick;

    assign kick = mon ^ mon_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            mon_prev_q <= 1'b0;
        end else begin
            mon_prev_q <= mon;
            if (hold || kick)      cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bite = !hold && !kick && (cnt_q == LAST);

    // R10: the count is cleared whenever reset is being held
    a_r10_clear_in_reset: assert property (@(posedge clk) disable iff (rst)
        hold |=> (cnt_q == '0));

    // R8: an edge on the monitor restarts the period
    a_r8_kick_restarts: assert property (@(posedge clk) disable iff (rst)
        (kick && !hold) |=> (cnt_q == '0));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int LOWV_FILT_CYC = 8,
    parameter int MAN_FILT_CYC  = 16,
    parameter int HOLD_CYC      = 1000,
    parameter int WDOG_CYC      = 5000,
    parameter int SYNC_STAGES   = 2,
    parameter int KICK_SEL      = KICK_PIN
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_low,
    input  logic man_rst_n,
    input  logic wd_kick,
    input  logic bus_sda,
    output logic rst_out,
    output logic rst_out_n
);
    localparam int HW = cnt_width(HOLD_CYC);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYC);

    logic   lowv_s, man_n_s, mon_s, mon_raw;
    cause_t cause;
    logic   cause_on;
    logic [HW-1:0] hold_q;

    assign mon_raw = (KICK_SEL == KICK_BUS) ? bus_sda : wd_kick;

    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lowv (
        .clk(clk), .rst(rst), .din(supply_low), .dout(lowv_s));
    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_man (
        .clk(clk), .rst(rst), .din(man_rst_n), .dout(man_n_s));
    sup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mon (
        .clk(clk), .rst(rst), .din(mon_raw), .dout(mon_s));

    sup_filter #(.LEN(LOWV_FILT_CYC), .INIT(1'b0)) u_filt_lowv (
        .clk(clk), .rst(rst), .din(lowv_s), .state(cause.lowv));
    sup_filter #(.LEN(MAN_FILT_CYC), .INIT(1'b0)) u_filt_man (
        .clk(clk), .rst(rst), .din(~man_n_s), .state(cause.man));

    sup_watchdog #(.CYC(WDOG_CYC)) u_wdog (
        .clk(clk), .rst(rst), .hold(rst_out), .mon(mon_s), .bite(cause.wdog));

    assign cause_on = cause_any(cause);

    always_ff @(posedge clk) begin
        if (rst || cause_on) hold_q <= HOLD_LOAD;
        else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end

    assign rst_out   = (hold_q != '0);
    assign rst_out_n = ~rst_out;

    // R5: any valid cause shows at the output on the next cycle
    a_r5_cause_asserts: assert property (@(posedge clk) disable iff (rst)
        cause_on |=> rst_out);

    // R5 / R6: release never follows a cycle in which a cause was present
    a_r6_release_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> !$past(cause_on));
endmodule

// File: tb/sup_reset_ctrl_bench.sv
`timescale 1ns/1ps
module sup_reset_ctrl_bench;
    localparam int LOWV = 3;
    localparam int MAN  = 6;
    localparam int HOLD = 12;
    localparam int WDOG = 40;
    localparam int KICK_PER = 24;

    // {source (0 supply, 1 manual), accepted, width[6:0]}
    localparam logic [8:0] VEC [0:6] = '{
        {1'b0, 1'b0, 7'd2},
        {1'b0, 1'b1, 7'd3},
        {1'b0, 1'b1, 7'd7},
        {1'b1, 1'b0, 7'd5},
        {1'b1, 1'b1, 7'd6},
        {1'b1, 1'b1, 7'd10},
        {1'b1, 1'b0, 7'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_low = 1'b0;
    logic man_rst_n = 1'b1;
    logic wd_kick = 1'b0;
    logic bus_sda = 1'b0;
    logic rst_out, rst_out_n, rst_out_b, rst_out_n_b;
    logic pin_en = 1'b1;
    logic sda_en = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    sup_reset_ctrl #(.LOWV_FILT_CYC(LOWV), .MAN_FILT_CYC(MAN), .HOLD_CYC(HOLD),
                     .WDOG_CYC(WDOG), .SYNC_STAGES(2), .KICK_SEL(0)) u_sup_reset_ctrl (
        .clk(clk), .rst(rst), .supply_low(supply_low), .man_rst_n(man_rst_n),
        .wd_kick(wd_kick), .bus_sda(bus_sda), .rst_out(rst_out), .rst_out_n(rst_out_n));

    sup_reset_ctrl #(.LOWV_FILT_CYC(LOWV), .MAN_FILT_CYC(MAN), .HOLD_CYC(HOLD),
                     .WDOG_CYC(WDOG), .SYNC_STAGES(2), .KICK_SEL(1)) u_sup_reset_ctrl_bus (
        .clk(clk), .rst(rst), .supply_low(supply_low), .man_rst_n(man_rst_n),
        .wd_kick(wd_kick), .bus_sda(bus_sda), .rst_out(rst_out_b), .rst_out_n(rst_out_n_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Kick generator: toggles the enabled monitor pins every KICK_PER cycles.
    initial begin
        forever begin
            for (int i = 0; i < KICK_PER; i++) @(negedge clk);
            if (pin_en) wd_kick = ~wd_kick;
            if (sda_en) bus_sda = ~bus_sda;
        end
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(negedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic wait_idle();
        for (int i = 0; i < 500 && rst_out; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input logic src, input logic acc, input int w);
        int len, rise, fall, win;
        bit comp;
        len = src ? MAN : LOWV;
        rise = 0; fall = 0; comp = 1'b1;
        win = w + len + HOLD + 8;
        if (src) man_rst_n = 1'b0; else supply_low = 1'b1;
        for (int n = 1; n <= win; n++) begin
            @(negedge clk);
            if (rst_out_n !== ~rst_out) comp = 1'b0;
            if (rise == 0 && rst_out) rise = n;
            if (rise != 0 && fall == 0 && !rst_out) fall = n;
            if (n == w) begin man_rst_n = 1'b1; supply_low = 1'b0; end
        end
        check(comp, "R1 complement", 0, 0);
        if (acc) begin
            check(rise == len + 3, src ? "R4 manual rise" : "R3 supply rise", rise, len + 3);
            check(fall == w + len + HOLD + 2, "R5 release", fall, w + len + HOLD + 2);
        end else begin
            check(rise == 0, src ? "R4 short manual ignored" : "R3 short supply ignored", rise, 0);
        end
    endtask

    initial begin
        int rise_a, rise_b, fall_a, rises;
        repeat (4) @(negedge clk);
        check(rst_out == 1'b1 && rst_out_n == 1'b0, "R2 reset state", rst_out, 1);
        check(rst_out_n == ~rst_out, "R1 reset complement", rst_out_n, ~rst_out);
        rst = 1'b0;
        fall_a = 0;
        for (int n = 1; n <= HOLD + 5 && fall_a == 0; n++) begin
            @(negedge clk);
            if (!rst_out) fall_a = n;
        end
        check(fall_a == HOLD, "R2 hold after block reset", fall_a, HOLD);

        // Vector table: filtered pulses on both causes
        for (int v = 0; v < 7; v++) begin
            wait_idle();
            run_vec(VEC[v][8], VEC[v][7], int'(VEC[v][6:0]));
        end

        // R6: manual reset arrives during the hold after a supply pulse
        wait_idle();
        rise_a = 0; fall_a = 0;
        supply_low = 1'b1;
        for (int n = 1; n <= 50; n++) begin
            @(negedge clk);
            if (rise_a == 0 && rst_out) rise_a = n;
            if (rise_a != 0 && fall_a == 0 && !rst_out) fall_a = n;
            if (n == 8) supply_low = 1'b0;
            if (n == 12) man_rst_n = 1'b0;
            if (n == 20) man_rst_n = 1'b1;
        end
        check(rise_a == LOWV + 3, "R6 first cause rise", rise_a, LOWV + 3);
        check(fall_a == 12 + 8 + MAN + HOLD + 2, "R6 hold restarted", fall_a, 12 + 8 + MAN + HOLD + 2);

        // R7 / R10: no kicks at all, exact bite timing on both variants
        pin_en = 1'b0; sda_en = 1'b0;
        supply_low = 1'b1;
        repeat (10) @(negedge clk);
        supply_low = 1'b0;
        for (int i = 0; i < 100 && rst_out; i++) @(negedge clk);
        rise_a = 0; rise_b = 0; fall_a = 0; rises = 0;
        for (int k = 1; k <= 2 * WDOG + HOLD + 5; k++) begin
            @(negedge clk);
            if (rise_a == 0 && rst_out) rise_a = k;
            if (rise_b == 0 && rst_out_b) rise_b = k;
            if (rise_a != 0 && fall_a == 0 && !rst_out) fall_a = k;
            if (fall_a != 0 && rises == 0 && rst_out) rises = k;
        end
        check(rise_a == WDOG, "R7 bite pin variant", rise_a, WDOG);
        check(rise_b == WDOG, "R7 bite bus variant", rise_b, WDOG);
        check(fall_a == WDOG + HOLD, "R7 hold after bite", fall_a, WDOG + HOLD);
        check(rises == 2 * WDOG + HOLD, "R10 full period after release", rises, 2 * WDOG + HOLD);

        // R8 / R9: kick pin toggling only
        pin_en = 1'b1;
        supply_low = 1'b1;
        repeat (10) @(negedge clk);
        supply_low = 1'b0;
        for (int i = 0; i < 100 && rst_out; i++) @(negedge clk);
        rise_a = 0; rises = 0;
        for (int k = 1; k <= 3 * WDOG; k++) begin
            @(negedge clk);
            if (rst_out) rise_a++;
            if (rst_out_b && !rises[0]) rises = 1;
        end
        check(rise_a == 0, "R8 both edges keep pin variant alive", rise_a, 0);
        check(rises == 1, "R9 bus variant ignores kick pin", rises, 1);

        // R9: bus data line toggling only
        pin_en = 1'b0; sda_en = 1'b1;
        supply_low = 1'b1;
        repeat (10) @(negedge clk);
        supply_low = 1'b0;
        for (int i = 0; i < 100 && rst_out_b; i++) @(negedge clk);
        rise_b = 0; rises = 0;
        for (int k = 1; k <= 3 * WDOG; k++) begin
            @(negedge clk);
            if (rst_out_b) rise_b++;
            if (rst_out && !rises[0]) rises = 1;
        end
        check(rise_b == 0, "R9 bus variant kept alive by data line", rise_b, 0);
        check(rises == 1, "R9 pin variant ignores data line", rises, 1);
        check(rst_out_n_b == ~rst_out_b, "R1 bus variant complement", rst_out_n_b, ~rst_out_b);

        finish_run();
    end
endmodule